// File: doc/BRIEF.md
# GF(2) Tile Multiply-Accumulate Array

This block multiplies a T-by-K bit tile by a K-by-T bit tile over GF(2). All T·T dot products are evaluated in parallel, so one tile product comes out per clock cycle. A wide multiply of two square bit matrices is broken into K-wide strips. For each strip pass, every output tile position is presented once, with its row tile and its column tile. The block folds the tile product into an on-chip result buffer indexed by tile position. The full matrix dimension must therefore be a multiple of K.

Over GF(2), each partial sum is an XOR. The first strip of a run stores its product directly. Every later strip XORs its product into the stored tile. Updates to the same tile in back-to-back cycles are forwarded so that none is lost. A read port returns any stored tile. A one-cycle completion pulse follows the commit of the tile that the controller marks as final.

Top module: `gf2_tile_mac`

## Requirements
- R1: Result bit (i, j), at index i*T+j of a tile, equals the XOR-reduction of the bitwise AND of row i (row_tile bits [i*K +: K]) and column j (col_tile bits [j*K +: K]).
- R2: An accepted input with first_strip high replaces the stored tile at tile_addr with the new product.
- R3: An accepted input with first_strip low stores the XOR of the new product and the tile's previous contents.
- R4: Inputs to the same tile_addr in consecutive cycles accumulate exactly as if they were spaced apart; no update is lost.
- R5: An accepted input changes only the tile at its own tile_addr, and its write commits on the clock edge after acceptance.
- R6: While in_valid is low, no tile changes and no done pulse is produced, whatever the other inputs carry.
- R7: done is high for exactly the one cycle that follows the commit of an input accepted with last_tile high, which is two edges after acceptance, and is low otherwise.
- R8: rd_data presents the tile at rd_addr one clock edge after the address is applied; after reset, rd_data and done are 0.
- R9: A new input is accepted on every cycle in_valid is high, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Tile pair present this cycle |
| first_strip | input | 1 | Overwrite rather than accumulate |
| last_tile | input | 1 | Final tile of the final strip |
| tile_addr | input | AW | Result tile position |
| row_tile | input | T*K | T rows of K bits, row i at [i*K +: K] |
| col_tile | input | T*K | T columns of K bits, column j at [j*K +: K] |
| rd_addr | input | AW | Result tile to read |
| rd_data | output | T*T | Stored tile, bit i*T+j is element (i, j) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims bursts of the same address at consecutive cycles. A design without forwarding would read stale contents there and drop one of the strips. It mixes first and non-first inputs to one tile. A design that swapped or ignored the overwrite control would keep old data or lose the accumulated sum. It drives garbage with in_valid low and then reads every tile, which exposes writes that were not gated. It also checks the exact cycle of the done pulse, where a pipeline off by one stage would pulse early or late.

// File: rtl/gf2_tile_mac.sv
module gf2_tile_mac #(
  parameter int T     = 32,
  parameter int K     = 96,
  parameter int TILES = 4,
  localparam int AW   = (TILES > 1) ? $clog2(TILES) : 1,
  localparam int TW   = T * K,
  localparam int RW   = T * T
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          first_strip,
  input  logic          last_tile,
  input  logic [AW-1:0] tile_addr,
  input  logic [TW-1:0] row_tile,
  input  logic [TW-1:0] col_tile,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_data,
  output logic          done
);

  logic [RW-1:0] prod;
  logic [RW-1:0] mem [TILES];

  for (genvar i = 0; i < T; i++) begin : g_row
    for (genvar j = 0; j < T; j++) begin : g_col
      assign prod[i*T+j] = ^(row_tile[i*K +: K] & col_tile[j*K +: K]);
    end
  end

  logic          s1_valid, s1_first, s1_last;
  logic [AW-1:0] s1_addr;
  logic [RW-1:0] s1_prod, s1_old;

  logic          wr_en, wr_last;
  logic [AW-1:0] wr_addr;
  logic [RW-1:0] wr_data;

  assign wr_en   = s1_valid;
  assign wr_last = s1_last;
  assign wr_addr = s1_addr;
  assign wr_data = s1_first ? s1_prod : (s1_prod ^ s1_old);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_addr  <= '0;
      done     <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_first <= first_strip;
      s1_last  <= in_valid & last_tile;
      s1_addr  <= tile_addr;
      done     <= wr_en & wr_last;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_prod <= prod;
      s1_old  <= (wr_en && wr_addr == tile_addr) ? wr_data : mem[tile_addr];
    end
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/gf2_tile_mac_chk.sv
module gf2_tile_mac_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          last_tile,
  input logic [AW-1:0] tile_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done
);

  logic          c_v1, c_l1, c_l2;
  logic [AW-1:0] c_a1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_v1 <= 1'b0;
      c_l1 <= 1'b0;
      c_l2 <= 1'b0;
      c_a1 <= '0;
    end else begin
      c_v1 <= in_valid;
      c_l1 <= in_valid & last_tile;
      c_l2 <= c_l1;
      c_a1 <= tile_addr;
    end
  end

  assert_write_each_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == c_v1);

  assert_write_own_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == c_a1);

  assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done == c_l2);

  assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !c_v1 |-> !wr_en);

  assert_reset_done_low_R8: assert property (@(posedge clk)
    !rst_n |=> !done);

endmodule

bind gf2_tile_mac gf2_tile_mac_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .last_tile(last_tile),
  .tile_addr(tile_addr), .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
);

// File: tb/gf2_tile_mac_bench.sv
module gf2_tile_mac_bench;
  localparam int T = 4, K = 8, TILES = 4, AW = 2, TW = T * K, RW = T * T;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          in_valid = 1'b0, first_strip = 1'b0, last_tile = 1'b0;
  logic [AW-1:0] tile_addr = '0, rd_addr = '0;
  logic [TW-1:0] row_tile = '0, col_tile = '0;
  logic [RW-1:0] rd_data;
  logic          done;

  int n_cmp = 0, n_bad = 0;
  logic [RW-1:0] model [TILES];
  logic          exp_done;

  always #10 clk = ~clk;

  gf2_tile_mac #(.T(T), .K(K), .TILES(TILES)) u_gf2_tile_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_strip(first_strip),
    .last_tile(last_tile), .tile_addr(tile_addr), .row_tile(row_tile),
    .col_tile(col_tile), .rd_addr(rd_addr), .rd_data(rd_data), .done(done));

  function automatic logic [RW-1:0] tile_prod(logic [TW-1:0] r, logic [TW-1:0] c);
    logic [RW-1:0] p = '0;
    for (int i = 0; i < T; i++)
      for (int j = 0; j < T; j++) begin
        logic b = 1'b0;
        for (int k = 0; k < K; k++) b ^= r[i*K+k] & c[j*K+k];
        p[i*T+j] = b;
      end
    return p;
  endfunction

  function automatic logic [TW-1:0] rnd_vec();
    logic [TW-1:0] v = '0;
    for (int w = 0; w < TW; w += 32) v = (v << 32) | TW'($urandom);
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [AW-1:0] a, logic f, logic l, logic [TW-1:0] r, logic [TW-1:0] c);
    in_valid = 1'b1; first_strip = f; last_tile = l; tile_addr = a;
    row_tile = r; col_tile = c;
    model[a] = f ? tile_prod(r, c) : (model[a] ^ tile_prod(r, c));
    exp_done = l;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flush(string req);
    in_valid = 1'b0; last_tile = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req, 64'(done), 64'(exp_done));
    @(posedge clk); @(negedge clk);
    check(req, 64'(done), 64'd0);
    exp_done = 1'b0;
  endtask

  task automatic read_tile(string req, logic [AW-1:0] a);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    check(req, 64'(rd_data), 64'(model[a]));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] r, c;
    void'($urandom(32'd12345));
    exp_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset rd_data", 64'(rd_data), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: row i = one-hot bit i, column j = one-hot bit j -> identity
    r = '0; c = '0;
    for (int i = 0; i < T; i++) begin r[i*K+i] = 1'b1; c[i*K+i] = 1'b1; end
    for (int a = 0; a < TILES; a++) issue(AW'(a), 1'b1, 1'b0, r, c);
    flush("R7 no done");
    read_tile("R1 identity", 2'd0);
    check("R1 identity value", 64'(model[0]), 64'h8421);
    // R1: all-ones rows/columns -> parity of K ones is 0
    issue(2'd1, 1'b1, 1'b0, '1, '1);
    flush("R7 no done");
    read_tile("R1 all ones", 2'd1);
    // R2 overwrite
    issue(2'd1, 1'b1, 1'b0, rnd_vec(), rnd_vec());
    flush("R7 no done");
    read_tile("R2 overwrite", 2'd1);
    // R3 accumulate, spaced
    issue(2'd2, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    flush("R7 no done");
    read_tile("R3 accumulate", 2'd2);
    // R4 back-to-back same address, R9 every cycle, R7 last
    issue(2'd3, 1'b1, 1'b0, rnd_vec(), rnd_vec());
    issue(2'd3, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    issue(2'd3, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    issue(2'd3, 1'b0, 1'b1, rnd_vec(), rnd_vec());
    flush("R7 done pulse");
    read_tile("R4 forwarding", 2'd3);
    // R5 interleaved addresses
    issue(2'd0, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    issue(2'd1, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    issue(2'd0, 1'b0, 1'b0, rnd_vec(), rnd_vec());
    flush("R7 no done");
    for (int a = 0; a < TILES; a++) read_tile("R5 independent tiles", AW'(a));
    // R6 garbage with in_valid low
    first_strip = 1'b1; last_tile = 1'b1;
    for (int n = 0; n < 8; n++) begin
      tile_addr = AW'(n); row_tile = rnd_vec(); col_tile = rnd_vec();
      @(posedge clk); @(negedge clk);
      check("R6 no done when idle", 64'(done), 64'd0);
    end
    last_tile = 1'b0;
    for (int a = 0; a < TILES; a++) read_tile("R6 unchanged", AW'(a));
    // random bursts
    for (int b = 0; b < 150; b++) begin
      int len = 1 + int'($urandom % 6);
      for (int s = 0; s < len; s++)
        issue(AW'($urandom), logic'(($urandom % 4) == 0),
              logic'((s == len - 1) && ($urandom % 2)), rnd_vec(), rnd_vec());
      flush("R7 random burst");
      read_tile("R3 R4 random", AW'($urandom));
    end
    for (int a = 0; a < TILES; a++) read_tile("R5 final", AW'(a));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule